// File: doc/BRIEF.md
# Programmable Audio Sample Rate Generator

The block turns one of two master-clock enable streams into two timing strobes for an audio converter: an oversampling strobe and a sample-rate strobe. A source-select bit chooses which master clock is counted. The divisor N sets how many master ticks make one oversampling period. A two-bit mode field sets the oversampling ratio M, that is, how many oversampling periods make one sample period. Each strobe is a single-cycle pulse in the fabric clock domain.

The rate comes from one of two paths. The alternate path uses the source select, N and the mode field. The legacy path uses a 4-bit rate code. An enable bit picks the alternate path, and a global block bit forces the legacy path whatever the enable bit says. A configuration that is out of range raises a flag and is not used. A new configuration takes hold only at a sample boundary, so no period is ever cut short.

Top module: `srg_rate_gen`

## Requirements
- R1: When the active source is 0, only cycles with `mclk_a_ce` high count as master ticks. When it is 1, only cycles with `mclk_b_ce` high count. The enable of the other source has no effect.
- R2: `os_strobe` pulses for one cycle once every N master ticks of the active source.
- R3: `fs_strobe` pulses once every N×M master ticks, and always in a cycle where `os_strobe` also pulses. `os_mode` 0 gives M=64, 1 gives M=128 and 2 gives M=256.
- R4: On the alternate path, the configuration is illegal when N is outside 16..49 with source 0, when N is outside 12..33 with source 1, or when `os_mode` is 3. `cfg_illegal` shows the legality of the inputs one cycle after they are applied.
- R5: An illegal configuration is never applied. The block keeps running on the last legal configuration.
- R6: A legal input change takes effect only at the next `fs_strobe` boundary, or in the first cycle after reset. Periods that are already under way finish with the old N and M.
- R7: When `alt_en` is 0, the legacy path sets the rate. `rate_code` bit 0 is the source, and bits 3:1 are an index k. N is 16+4k for source 0 and 12+3k for source 1, and M is 64.
- R8: When `alt_block` is 1, the legacy path sets the rate even if `alt_en` is 1.
- R9: During reset, both strobes and `cfg_illegal` are 0. The configuration held in reset is source 0, N=16, M=64.
- R10: While the alternate path is active, `rate_code` has no effect on either strobe period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_a_ce | input | 1 | Master tick enable for source 0 |
| mclk_b_ce | input | 1 | Master tick enable for source 1 |
| src_sel | input | 1 | Alternate-path source select |
| div_n | input | 6 | Alternate-path divisor N |
| os_mode | input | 2 | Alternate-path oversampling mode |
| alt_en | input | 1 | Selects the alternate path |
| alt_block | input | 1 | Global override that forces the legacy path |
| rate_code | input | 4 | Legacy rate code |
| os_strobe | output | 1 | Oversampling strobe |
| fs_strobe | output | 1 | Sample-rate strobe |
| cfg_illegal | output | 1 | The current inputs form an illegal configuration |

## Verification
A corrupted tick counter shows up at the ports as an oversampling period other than N, within one period. A corrupted ratio counter shows up as a sample period other than N×M, within one sample period. A held configuration that is applied at the wrong time makes the oversampling period change before the next sample strobe. An illegal configuration that is wrongly applied shows up as a changed period right after the next boundary. For these reasons the bench measures the strobe spacing in cycles, both just before and just after each boundary. It steps the enable of each source to show which source is being counted.

// File: rtl/srg_pkg.sv
package srg_pkg;
  parameter int SRG_NW = 6;
  parameter int SRG_MODEW = 2;

  typedef struct packed {
    logic                 src;
    logic [SRG_NW-1:0]    n;
    logic [SRG_MODEW-1:0] mode;
  } srg_cfg_t;
endpackage

// File: rtl/srg_cfg_select.sv
module srg_cfg_select
  import srg_pkg::*;
#(
  parameter int MIN0   = 16,
  parameter int MAX0   = 49,
  parameter int MIN1   = 12,
  parameter int MAX1   = 33,
  parameter int LSTEP0 = 4,
  parameter int LSTEP1 = 3,
  parameter int CODEW  = 4
) (
  input  logic                 alt_en,
  input  logic                 alt_block,
  input  logic                 src_sel,
  input  logic [SRG_NW-1:0]    div_n,
  input  logic [SRG_MODEW-1:0] os_mode,
  input  logic [CODEW-1:0]     rate_code,
  output srg_cfg_t             cand,
  output logic                 cand_ok
);
  localparam int KW = CODEW - 1;

  logic [KW-1:0] leg_k;
  logic          use_alt;
  int            n_val;

  assign leg_k   = rate_code[CODEW-1:1];
  assign use_alt = alt_en && !alt_block;

  always_comb begin
    if (use_alt) begin
      cand.src  = src_sel;
      cand.n    = div_n;
      cand.mode = os_mode;
    end else begin
      cand.src  = rate_code[0];
      cand.n    = rate_code[0] ? SRG_NW'(MIN1 + LSTEP1 * int'(leg_k))
                               : SRG_NW'(MIN0 + LSTEP0 * int'(leg_k));
      cand.mode = '0;
    end
    n_val   = int'(cand.n);
    cand_ok = (cand.mode != 2'b11) &&
              (cand.src ? (n_val >= MIN1 && n_val <= MAX1)
                        : (n_val >= MIN0 && n_val <= MAX0));
  end
endmodule

// File: rtl/srg_cfg_hold.sv
module srg_cfg_hold
  import srg_pkg::*;
#(
  parameter int MIN0  = 16,
  parameter int MAX0  = 49,
  parameter int MIN1  = 12,
  parameter int MAX1  = 33,
  parameter int RST_N = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  srg_cfg_t cand,
  input  logic     cand_ok,
  input  logic     boundary,
  output srg_cfg_t act,
  output logic     prime
);
  logic load;
  assign load = (prime || boundary) && cand_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      prime    <= 1'b1;
      act.src  <= 1'b0;
      act.n    <= SRG_NW'(RST_N);
      act.mode <= '0;
    end else begin
      prime <= 1'b0;
      if (load) act <= cand;
    end
  end

  assert_active_legal_R5: assert property (@(posedge clk) disable iff (rst)
    (act.mode != 2'b11) &&
    (act.src ? (int'(act.n) >= MIN1 && int'(act.n) <= MAX1)
             : (int'(act.n) >= MIN0 && int'(act.n) <= MAX0)));

  assert_change_at_boundary_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(act) |-> $past(prime || boundary));
endmodule

// File: rtl/srg_divider.sv
module srg_divider
  import srg_pkg::*;
#(
  parameter int MBASE = 6
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  input  logic     ce_a,
  input  logic     ce_b,
  input  srg_cfg_t act,
  output logic     os_strobe,
  output logic     fs_strobe,
  output logic     boundary
);
  localparam int MW = MBASE + 2;

  logic [SRG_NW-1:0] os_cnt;
  logic [MW-1:0]     m_cnt;
  logic [MW-1:0]     m_last;
  logic              tick, os_term, m_term;

  always_comb begin
    m_last  = MW'((1 << (MBASE + int'(act.mode))) - 1);
    tick    = (act.src ? ce_b : ce_a) && !hold;
    os_term = (os_cnt == act.n - SRG_NW'(1));
    m_term  = (m_cnt == m_last);
  end
  assign boundary = tick && os_term && m_term;

  always_ff @(posedge clk) begin
    if (rst) begin
      os_cnt    <= '0;
      m_cnt     <= '0;
      os_strobe <= 1'b0;
      fs_strobe <= 1'b0;
    end else begin
      os_strobe <= tick && os_term;
      fs_strobe <= boundary;
      if (tick) begin
        os_cnt <= os_term ? '0 : os_cnt + SRG_NW'(1);
        if (os_term) m_cnt <= m_term ? '0 : m_cnt + MW'(1);
      end
    end
  end

  assert_os_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    os_cnt < act.n);

  assert_fs_with_os_R3: assert property (@(posedge clk) disable iff (rst)
    fs_strobe |-> os_strobe);
endmodule

// File: rtl/srg_rate_gen.sv
module srg_rate_gen
  import srg_pkg::*;
#(
  parameter int MIN0   = 16,
  parameter int MAX0   = 49,
  parameter int MIN1   = 12,
  parameter int MAX1   = 33,
  parameter int LSTEP0 = 4,
  parameter int LSTEP1 = 3,
  parameter int CODEW  = 4,
  parameter int MBASE  = 6,
  parameter int RST_N  = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mclk_a_ce,
  input  logic                 mclk_b_ce,
  input  logic                 src_sel,
  input  logic [SRG_NW-1:0]    div_n,
  input  logic [SRG_MODEW-1:0] os_mode,
  input  logic                 alt_en,
  input  logic                 alt_block,
  input  logic [CODEW-1:0]     rate_code,
  output logic                 os_strobe,
  output logic                 fs_strobe,
  output logic                 cfg_illegal
);
  srg_cfg_t cand, act;
  logic     cand_ok, prime, boundary;

  srg_cfg_select #(
    .MIN0(MIN0), .MAX0(MAX0), .MIN1(MIN1), .MAX1(MAX1),
    .LSTEP0(LSTEP0), .LSTEP1(LSTEP1), .CODEW(CODEW)
  ) u_sel (
    .alt_en(alt_en), .alt_block(alt_block), .src_sel(src_sel),
    .div_n(div_n), .os_mode(os_mode), .rate_code(rate_code),
    .cand(cand), .cand_ok(cand_ok)
  );

  srg_cfg_hold #(
    .MIN0(MIN0), .MAX0(MAX0), .MIN1(MIN1), .MAX1(MAX1), .RST_N(RST_N)
  ) u_hold (
    .clk(clk), .rst(rst), .cand(cand), .cand_ok(cand_ok),
    .boundary(boundary), .act(act), .prime(prime)
  );

  srg_divider #(.MBASE(MBASE)) u_div (
    .clk(clk), .rst(rst), .hold(prime), .ce_a(mclk_a_ce), .ce_b(mclk_b_ce),
    .act(act), .os_strobe(os_strobe), .fs_strobe(fs_strobe),
    .boundary(boundary)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_illegal <= 1'b0;
    else     cfg_illegal <= !cand_ok;
  end

  assert_reserved_mode_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (alt_en && !alt_block && os_mode == 2'b11) |=> cfg_illegal);
endmodule

// File: tb/srg_rate_gen_test.sv
module srg_rate_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce_a = 1'b1, ce_b = 1'b1;
  logic       a_tog = 1'b0, b_tog = 1'b0;
  logic       src_sel = 1'b0;
  logic [5:0] div_n = 6'd16;
  logic [1:0] os_mode = 2'd0;
  logic       alt_en = 1'b1, alt_block = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       os_strobe, fs_strobe, cfg_illegal;

  int n_chk = 0, n_bad = 0, cyc = 0;

  srg_rate_gen uut (
    .clk(clk), .rst(rst), .mclk_a_ce(ce_a), .mclk_b_ce(ce_b),
    .src_sel(src_sel), .div_n(div_n), .os_mode(os_mode),
    .alt_en(alt_en), .alt_block(alt_block), .rate_code(rate_code),
    .os_strobe(os_strobe), .fs_strobe(fs_strobe), .cfg_illegal(cfg_illegal)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    ce_a <= a_tog ? ~ce_a : 1'b1;
    ce_b <= b_tog ? ~ce_b : 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected below 190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic meas(input bit use_fs, output int p);
    while (!(use_fs ? fs_strobe : os_strobe)) @(negedge clk);
    p = 0;
    do begin
      @(negedge clk);
      p++;
    end while (!(use_fs ? fs_strobe : os_strobe));
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!fs_strobe);
  endtask

  task automatic set_alt(input bit s, input int n, input int m);
    alt_en = 1'b1; alt_block = 1'b0;
    src_sel = s; div_n = 6'(n); os_mode = 2'(m);
  endtask

  task automatic t_reset();
    int p;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R9 os_strobe in reset", int'(os_strobe), 0);
      chk("R9 fs_strobe in reset", int'(fs_strobe), 0);
      chk("R9 cfg_illegal in reset", int'(cfg_illegal), 0);
    end
    rst = 1'b0;
    meas(1'b0, p); chk("R2 os period N=16", p, 16);
    meas(1'b1, p); chk("R3 fs period 16x64", p, 1024);
  endtask

  task automatic t_modes();
    int p;
    set_alt(1'b0, 20, 1);
    wait_fs();
    meas(1'b0, p); chk("R2 os period N=20", p, 20);
    meas(1'b1, p); chk("R3 fs period 20x128", p, 2560);
    set_alt(1'b1, 12, 2);
    wait_fs();
    meas(1'b1, p); chk("R3 fs period 12x256", p, 3072);
  endtask

  task automatic t_source();
    int p;
    set_alt(1'b1, 12, 0);
    a_tog = 1'b1; b_tog = 1'b0;
    wait_fs();
    meas(1'b0, p); chk("R1 source 1 ignores ce_a", p, 12);
    a_tog = 1'b0; b_tog = 1'b1;
    repeat (3) @(negedge clk);
    meas(1'b0, p); chk("R1 source 1 counts ce_b", p, 24);
    set_alt(1'b0, 16, 0);
    wait_fs();
    meas(1'b0, p); chk("R1 source 0 ignores ce_b", p, 16);
    a_tog = 1'b1; b_tog = 1'b0;
    repeat (3) @(negedge clk);
    meas(1'b0, p); chk("R1 source 0 counts ce_a", p, 32);
    a_tog = 1'b0;
  endtask

  task automatic t_boundary();
    int p;
    set_alt(1'b0, 16, 0);
    wait_fs();
    wait_fs();
    set_alt(1'b0, 25, 0);
    meas(1'b0, p); chk("R6 old N holds before boundary", p, 16);
    wait_fs();
    meas(1'b0, p); chk("R6 new N after boundary", p, 25);
    meas(1'b1, p); chk("R6 new fs period", p, 1600);
  endtask

  task automatic t_legality();
    int p;
    set_alt(1'b0, 16, 0);
    wait_fs();
    @(negedge clk); set_alt(1'b1, 34, 0);
    @(negedge clk); chk("R4 src1 N=34 illegal", int'(cfg_illegal), 1);
    set_alt(1'b1, 33, 0);
    @(negedge clk); chk("R4 src1 N=33 legal", int'(cfg_illegal), 0);
    set_alt(1'b1, 11, 0);
    @(negedge clk); chk("R4 src1 N=11 illegal", int'(cfg_illegal), 1);
    set_alt(1'b0, 15, 0);
    @(negedge clk); chk("R4 src0 N=15 illegal", int'(cfg_illegal), 1);
    set_alt(1'b0, 49, 0);
    @(negedge clk); chk("R4 src0 N=49 legal", int'(cfg_illegal), 0);
    set_alt(1'b0, 50, 0);
    @(negedge clk); chk("R4 src0 N=50 illegal", int'(cfg_illegal), 1);
    set_alt(1'b0, 16, 3);
    @(negedge clk); chk("R4 mode 3 illegal", int'(cfg_illegal), 1);
    set_alt(1'b1, 40, 0);
    wait_fs();
    meas(1'b0, p); chk("R5 illegal config not applied", p, 16);
    meas(1'b1, p); chk("R5 fs keeps last legal", p, 1024);
  endtask

  task automatic t_legacy();
    int p;
    alt_en = 1'b0; rate_code = 4'b0101;
    wait_fs();
    meas(1'b0, p); chk("R7 code 0101 N=18", p, 18);
    meas(1'b1, p); chk("R7 legacy M=64", p, 1152);
    rate_code = 4'b0110;
    wait_fs();
    meas(1'b0, p); chk("R7 code 0110 N=28", p, 28);
    set_alt(1'b0, 40, 1);
    alt_block = 1'b1;
    @(negedge clk); chk("R8 blocked path no flag", int'(cfg_illegal), 0);
    wait_fs();
    meas(1'b0, p); chk("R8 override forces legacy", p, 28);
    alt_block = 1'b0;
    wait_fs();
    meas(1'b0, p); chk("R8 release selects alternate", p, 40);
    rate_code = 4'b1111;
    wait_fs();
    meas(1'b0, p); chk("R10 rate_code ignored os", p, 40);
    meas(1'b1, p); chk("R10 rate_code ignored fs", p, 5120);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_source();
    t_boundary();
    t_legality();
    t_legacy();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule